// File: doc/BRIEF.md
# Per-Warp Reduced Dependency Scoreboard

This block sits in the issue stage of a multithreaded SIMT core and tracks register write hazards. It does not keep one bit per architectural register. Each warp owns a small pool of tracking entries, and each entry holds one destination register that an issued instruction has not yet written back. An instruction is placed in one of its warp's buffer slots, and the block then compares its source and destination registers against the live entries of that warp. The matches are stored as a dependency bitvector next to the buffered instruction, with one bit for each entry.

When an instruction issues and names a destination, the block claims the lowest free entry of its warp for that register. It reports the entry index, and the writeback later returns that index together with the warp ID. A writeback releases its entry and clears the matching bit in every buffered instruction of that warp, so writebacks may arrive in any order. A slot is offered to the scheduler only when all of the following hold: its vector is zero, and, if it needs an entry, its warp still has one free. Choosing among the ready slots is left to the scheduler.

Top module: `warp_dep_scoreboard`

## Requirements
- R1: After reset every slot is empty, every entry is free, all `slot_ready` bits are 0, and an issue request is not granted.
- R2: A decode into an empty slot stores a vector in which bit e is set exactly when entry e of that warp is live and holds a register equal to a valid source (read-after-write) or to the valid destination (write-after-write).
- R3: A decode aimed at a slot that is already occupied is ignored, and the slot keeps its previous contents and readiness.
- R4: `slot_ready` bit (warp*SLOTS + slot) is 1 exactly when that slot is occupied, its vector is zero, and either it has no destination or its warp has at least one free entry.
- R5: An issue request for a ready slot raises `iss_grant` in the same cycle and empties the slot at the next edge. A request for a slot that is not ready is ignored.
- R6: A granted instruction with a destination raises `iss_alloc`, and `iss_entry` gives the lowest-numbered free entry of its warp. That entry becomes live with that register.
- R7: When all entries of a warp are live, a slot of that warp with a destination is held not ready, while a slot of that warp without a destination can still be ready.
- R8: A writeback (warp, entry) frees that entry and clears bit `entry` in every slot of that warp. Other warps are left unchanged.
- R9: A writeback in the same cycle as a decode of the same warp takes priority, so the entry it frees is not recorded in the new vector.
- R10: An entry allocated by an issue in the same cycle as a decode of the same warp is visible to that decode.
- R11: Writebacks may release entries in any order. Each one affects only the entry it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Place a decoded instruction |
| dec_warp | input | WARP_W | Warp of the decoded instruction |
| dec_slot | input | SLOT_W | Target buffer slot |
| dec_src_a_valid | input | 1 | Source A is used |
| dec_src_a | input | REG_W | Source A register |
| dec_src_b_valid | input | 1 | Source B is used |
| dec_src_b | input | REG_W | Source B register |
| dec_dst_valid | input | 1 | Instruction writes a destination |
| dec_dst | input | REG_W | Destination register |
| iss_valid | input | 1 | Scheduler requests issue of a slot |
| iss_warp | input | WARP_W | Warp of the issue request |
| iss_slot | input | SLOT_W | Slot of the issue request |
| iss_grant | output | 1 | Issue accepted this cycle |
| iss_alloc | output | 1 | Accepted issue claimed an entry |
| iss_entry | output | IDX_W | Index of the claimed entry |
| wb_valid | input | 1 | A result is written back |
| wb_warp | input | WARP_W | Warp of the writeback |
| wb_entry | input | IDX_W | Entry released by the writeback |
| slot_ready | output | NUM_WARPS*SLOTS | Ready flag per slot, warp-major |

## Verification
The bench targets several corner cases. One is a writeback landing in the same cycle as a dependent decode: a design without the priority would record a stale bit, and that slot would never become ready. Another is an issue allocating an entry in the same cycle as a decode of the same warp. Without the bypass, that decode would miss a read-after-write hazard and be offered too early. The bench also fills every entry of a warp, where a wrong design would either claim a busy entry or block instructions that have no destination. It releases entries out of order, which exposes designs that free the wrong entry or clear bits in other warps. A long pseudo-random run is compared against an arithmetic model of every slot on every cycle.

// File: rtl/wds_pkg.sv
// Shared helpers for the per-warp dependency scoreboard.
// Assumes the per-warp entry count does not exceed 32.
package wds_pkg;

    // Returns the index of the lowest set bit, or 32 when none is set.
    function automatic int unsigned lowest_set(input logic [31:0] v);
        int unsigned idx;
        idx = 32;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/wds_entry_bank.sv
// Tracking entries of one warp: live flag and destination register per entry.
// Computes the post-writeback, post-allocation view of the entries and
// matches up to three decode operands against it.
// Assumes alloc_en is only raised while has_free is 1.
module wds_entry_bank #(
    parameter int ENTRIES = 6,
    parameter int REG_W   = 7,
    parameter int IDX_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_en,
    input  logic [REG_W-1:0]        alloc_reg,
    input  logic                    clr_en,
    input  logic [IDX_W-1:0]        clr_idx,
    input  logic [2:0]              q_valid,
    input  logic [2:0][REG_W-1:0]   q_reg,
    output logic [ENTRIES-1:0]      hit_vec,
    output logic                    has_free,
    output logic [IDX_W-1:0]        free_idx
);
    import wds_pkg::*;

    logic [ENTRIES-1:0]             live_q, live_n;
    logic [ENTRIES-1:0][REG_W-1:0]  reg_q, reg_n;

    // Lowest free entry of the current state.
    always_comb begin
        has_free = |(~live_q);
        free_idx = IDX_W'(lowest_set(32'(~live_q)));
    end

    // Next state: writeback release first, then allocation.
    always_comb begin
        live_n = live_q;
        reg_n  = reg_q;
        if (clr_en) live_n[clr_idx] = 1'b0;
        if (alloc_en) begin
            live_n[free_idx] = 1'b1;
            reg_n[free_idx]  = alloc_reg;
        end
    end

    // Operand match against the next-state view.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            hit_vec[e] = live_n[e] &&
                         ((q_valid[0] && q_reg[0] == reg_n[e]) ||
                          (q_valid[1] && q_reg[1] == reg_n[e]) ||
                          (q_valid[2] && q_reg[2] == reg_n[e]));
        end
    end

    // Entry state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            reg_q  <= '0;
        end else begin
            live_q <= live_n;
            reg_q  <= reg_n;
        end
    end

endmodule

// File: rtl/wds_slot_bank.sv
// Instruction buffer bookkeeping of one warp: occupancy, dependency vector
// and destination per slot, plus the ready decision.
// Assumes ins_vec already excludes any entry released in the same cycle.
module wds_slot_bank #(
    parameter int SLOTS   = 2,
    parameter int ENTRIES = 6,
    parameter int REG_W   = 7,
    parameter int SLOT_W  = 1,
    parameter int IDX_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ins_en,
    input  logic [SLOT_W-1:0]       ins_slot,
    input  logic [ENTRIES-1:0]      ins_vec,
    input  logic                    ins_dst_v,
    input  logic [REG_W-1:0]        ins_dst,
    input  logic                    rm_en,
    input  logic [SLOT_W-1:0]       rm_slot,
    input  logic                    clr_en,
    input  logic [IDX_W-1:0]        clr_idx,
    input  logic                    has_free,
    output logic [SLOTS-1:0]        ready,
    output logic [SLOTS-1:0]        slot_dst_v,
    output logic [SLOTS-1:0][REG_W-1:0] slot_dst
);
    logic [SLOTS-1:0]               occ_q;
    logic [SLOTS-1:0][ENTRIES-1:0]  vec_q;
    logic [ENTRIES-1:0]             clr_mask;

    // Bit to drop from every vector on a writeback.
    always_comb clr_mask = clr_en ? (ENTRIES'(1) << clr_idx) : '0;

    // Ready when occupied, hazard-free, and an entry exists if needed.
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            ready[s] = occ_q[s] && (vec_q[s] == '0) && (!slot_dst_v[s] || has_free);
        end
    end

    // Slot state: clear-in-place, removal on issue, insert into empty slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q      <= '0;
            vec_q      <= '0;
            slot_dst_v <= '0;
            slot_dst   <= '0;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                vec_q[s] <= vec_q[s] & ~clr_mask;
                if (rm_en && rm_slot == SLOT_W'(s)) occ_q[s] <= 1'b0;
                if (ins_en && ins_slot == SLOT_W'(s) && !occ_q[s]) begin
                    occ_q[s]      <= 1'b1;
                    vec_q[s]      <= ins_vec;
                    slot_dst_v[s] <= ins_dst_v;
                    slot_dst[s]   <= ins_dst;
                end
            end
        end
    end

endmodule

// File: rtl/warp_dep_scoreboard.sv
// Per-warp reduced dependency scoreboard. One entry bank and one slot bank
// per warp. Decode vectors are built against the entry state after this
// cycle's writeback and allocation. Assumes NUM_WARPS and SLOTS are powers
// of two and that the scheduler only names existing warps and slots.
module warp_dep_scoreboard #(
    parameter int NUM_WARPS = 32,
    parameter int NUM_REGS  = 128,
    parameter int ENTRIES   = 6,
    parameter int SLOTS     = 2,
    localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dec_valid,
    input  logic [WARP_W-1:0]           dec_warp,
    input  logic [SLOT_W-1:0]           dec_slot,
    input  logic                        dec_src_a_valid,
    input  logic [REG_W-1:0]            dec_src_a,
    input  logic                        dec_src_b_valid,
    input  logic [REG_W-1:0]            dec_src_b,
    input  logic                        dec_dst_valid,
    input  logic [REG_W-1:0]            dec_dst,
    input  logic                        iss_valid,
    input  logic [WARP_W-1:0]           iss_warp,
    input  logic [SLOT_W-1:0]           iss_slot,
    output logic                        iss_grant,
    output logic                        iss_alloc,
    output logic [IDX_W-1:0]            iss_entry,
    input  logic                        wb_valid,
    input  logic [WARP_W-1:0]           wb_warp,
    input  logic [IDX_W-1:0]            wb_entry,
    output logic [NUM_WARPS*SLOTS-1:0]  slot_ready
);
    logic [ENTRIES-1:0]             w_hit      [NUM_WARPS];
    logic                           w_free     [NUM_WARPS];
    logic [IDX_W-1:0]               w_free_idx [NUM_WARPS];
    logic [SLOTS-1:0]               w_ready    [NUM_WARPS];
    logic [SLOTS-1:0]               w_sdv      [NUM_WARPS];
    logic [SLOTS-1:0][REG_W-1:0]    w_sd       [NUM_WARPS];
    logic [2:0]                     q_valid;
    logic [2:0][REG_W-1:0]          q_reg;

    // Decode operands shared by every warp's matcher.
    always_comb begin
        q_valid = {dec_dst_valid, dec_src_b_valid, dec_src_a_valid};
        q_reg   = {dec_dst, dec_src_b, dec_src_a};
    end

    // Issue acceptance and entry report for the requested slot.
    always_comb begin
        iss_grant = iss_valid && w_ready[iss_warp][iss_slot];
        iss_alloc = iss_grant && w_sdv[iss_warp][iss_slot];
        iss_entry = w_free_idx[iss_warp];
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        wds_entry_bank #(
            .ENTRIES (ENTRIES),
            .REG_W   (REG_W),
            .IDX_W   (IDX_W)
        ) u_entries (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_en  (iss_alloc && iss_warp == WARP_W'(w)),
            .alloc_reg (w_sd[w][iss_slot]),
            .clr_en    (wb_valid && wb_warp == WARP_W'(w)),
            .clr_idx   (wb_entry),
            .q_valid   (q_valid),
            .q_reg     (q_reg),
            .hit_vec   (w_hit[w]),
            .has_free  (w_free[w]),
            .free_idx  (w_free_idx[w])
        );

        wds_slot_bank #(
            .SLOTS   (SLOTS),
            .ENTRIES (ENTRIES),
            .REG_W   (REG_W),
            .SLOT_W  (SLOT_W),
            .IDX_W   (IDX_W)
        ) u_slots (
            .clk        (clk),
            .rst_n      (rst_n),
            .ins_en     (dec_valid && dec_warp == WARP_W'(w)),
            .ins_slot   (dec_slot),
            .ins_vec    (w_hit[w]),
            .ins_dst_v  (dec_dst_valid),
            .ins_dst    (dec_dst),
            .rm_en      (iss_grant && iss_warp == WARP_W'(w)),
            .rm_slot    (iss_slot),
            .clr_en     (wb_valid && wb_warp == WARP_W'(w)),
            .clr_idx    (wb_entry),
            .has_free   (w_free[w]),
            .ready      (w_ready[w]),
            .slot_dst_v (w_sdv[w]),
            .slot_dst   (w_sd[w])
        );

        assign slot_ready[w*SLOTS +: SLOTS] = w_ready[w];
    end

endmodule

// File: rtl/wds_checker.sv
// Temporal checks on the scoreboard ports; attached by bind below.
// Assumes the reset is held for at least one clock edge at start.
module wds_checker #(
    parameter int NUM_WARPS = 32,
    parameter int ENTRIES   = 6,
    parameter int SLOTS     = 2,
    parameter int WARP_W    = 5,
    parameter int SLOT_W    = 1,
    parameter int IDX_W     = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       dec_valid,
    input logic                       wb_valid,
    input logic [WARP_W-1:0]          iss_warp,
    input logic [SLOT_W-1:0]          iss_slot,
    input logic                       iss_grant,
    input logic                       iss_alloc,
    input logic [IDX_W-1:0]           iss_entry,
    input logic [NUM_WARPS*SLOTS-1:0] slot_ready
);
    localparam int IW = (NUM_WARPS*SLOTS > 1) ? $clog2(NUM_WARPS*SLOTS) : 1;

    logic          first_q;
    logic [IW-1:0] cur_idx;

    // Marks the first cycle after reset release.
    always_ff @(posedge clk) first_q <= !rst_n;

    // Flat index of the requested slot.
    always_comb cur_idx = IW'(int'(iss_warp) * SLOTS + int'(iss_slot));

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> slot_ready == '0);

    p_issue_frees_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant |=> !slot_ready[$past(cur_idx)]);

    p_alloc_entry_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_alloc |-> (iss_grant && (int'(iss_entry) < ENTRIES)));

    for (genvar k = 0; k < NUM_WARPS*SLOTS; k++) begin : g_rise
        p_ready_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(slot_ready[k]) |-> $past(dec_valid || wb_valid));
    end

endmodule

bind warp_dep_scoreboard wds_checker #(
    .NUM_WARPS (NUM_WARPS),
    .ENTRIES   (ENTRIES),
    .SLOTS     (SLOTS),
    .WARP_W    (WARP_W),
    .SLOT_W    (SLOT_W),
    .IDX_W     (IDX_W)
) u_chk (.*);

// File: tb/warp_dep_scoreboard_tb.sv
// Bench for the scoreboard on a small configuration: directed corner cases,
// then a pseudo-random run checked every cycle against an arithmetic model.
module warp_dep_scoreboard_tb;
    localparam int W = 4;
    localparam int R = 16;
    localparam int E = 3;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 0, dec_src_a_valid = 0, dec_src_b_valid = 0, dec_dst_valid = 0;
    logic [1:0] dec_warp = 0, iss_warp = 0, wb_warp = 0, wb_entry = 0;
    logic       dec_slot = 0, iss_slot = 0;
    logic [3:0] dec_src_a = 0, dec_src_b = 0, dec_dst = 0;
    logic       iss_valid = 0, wb_valid = 0;
    logic       iss_grant, iss_alloc;
    logic [1:0] iss_entry;
    logic [W*S-1:0] slot_ready;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Model state.
    bit busy [W][E];
    int regs [W][E];
    bit sv   [W][S];
    int vec  [W][S];
    bit sdv  [W][S];
    int sd   [W][S];

    always #2 clk = ~clk;

    warp_dep_scoreboard #(.NUM_WARPS(W), .NUM_REGS(R), .ENTRIES(E), .SLOTS(S)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_warp(dec_warp), .dec_slot(dec_slot),
        .dec_src_a_valid(dec_src_a_valid), .dec_src_a(dec_src_a),
        .dec_src_b_valid(dec_src_b_valid), .dec_src_b(dec_src_b),
        .dec_dst_valid(dec_dst_valid), .dec_dst(dec_dst),
        .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_slot(iss_slot),
        .iss_grant(iss_grant), .iss_alloc(iss_alloc), .iss_entry(iss_entry),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_entry(wb_entry),
        .slot_ready(slot_ready)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int free_idx(input int w);
        for (int e = 0; e < E; e++) if (!busy[w][e]) return e;
        return E;
    endfunction

    function automatic bit m_ready(input int w, input int s);
        return sv[w][s] && vec[w][s] == 0 && (!sdv[w][s] || free_idx(w) < E);
    endfunction

    // One clock: drive at the falling edge, compare, commit the model at the rising edge.
    task automatic cycle(input string tag,
                         input int dv, input int dw, input int ds,
                         input int dav, input int da, input int dbv, input int db,
                         input int ddv, input int dd,
                         input int iv, input int iw, input int is,
                         input int wv, input int ww, input int we);
        int exp_rdy, ent, dvec;
        bit grant, alloc, ins_ok;
        bit nb [W][E];
        int nr [W][E];
        dec_valid = dv[0]; dec_warp = 2'(dw); dec_slot = ds[0];
        dec_src_a_valid = dav[0]; dec_src_a = 4'(da);
        dec_src_b_valid = dbv[0]; dec_src_b = 4'(db);
        dec_dst_valid = ddv[0]; dec_dst = 4'(dd);
        iss_valid = iv[0]; iss_warp = 2'(iw); iss_slot = is[0];
        wb_valid = wv[0]; wb_warp = 2'(ww); wb_entry = 2'(we);
        #1;
        exp_rdy = 0;
        for (int w = 0; w < W; w++)
            for (int s = 0; s < S; s++)
                if (m_ready(w, s)) exp_rdy |= (1 << (w*S + s));
        grant = iv != 0 && m_ready(iw, is);
        alloc = grant && sdv[iw][is];
        ent = free_idx(iw);
        check(tag, "slot_ready", int'(slot_ready), exp_rdy);
        check(tag, "iss_grant", int'(iss_grant), int'(grant));
        check(tag, "iss_alloc", int'(iss_alloc), int'(alloc));
        if (alloc) check(tag, "iss_entry", int'(iss_entry), ent);
        nb = busy; nr = regs;
        if (wv != 0) nb[ww][we] = 0;
        if (alloc) begin nb[iw][ent] = 1; nr[iw][ent] = sd[iw][is]; end
        dvec = 0;
        for (int e = 0; e < E; e++)
            if (nb[dw][e] && ((dav != 0 && nr[dw][e] == da) || (dbv != 0 && nr[dw][e] == db) ||
                              (ddv != 0 && nr[dw][e] == dd)))
                dvec |= (1 << e);
        ins_ok = dv != 0 && !sv[dw][ds];
        @(posedge clk);
        if (wv != 0) for (int s = 0; s < S; s++) vec[ww][s] &= ~(1 << we);
        if (grant) sv[iw][is] = 0;
        if (ins_ok) begin
            sv[dw][ds] = 1; vec[dw][ds] = dvec; sdv[dw][ds] = ddv != 0; sd[dw][ds] = dd;
        end
        busy = nb; regs = nr;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        cycle(tag, 0,0,0, 0,0,0,0, 0,0, 0,0,0, 0,0,0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned x;
        for (int w = 0; w < W; w++) begin
            for (int e = 0; e < E; e++) begin busy[w][e] = 0; regs[w][e] = 0; end
            for (int s = 0; s < S; s++) begin sv[w][s] = 0; vec[w][s] = 0; sdv[w][s] = 0; sd[w][s] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing ready and an issue request is refused
        cycle("R1", 0,0,0, 0,0,0,0, 0,0, 1,0,0, 0,0,0);
        // R4: warp 0 slot 0 writes r5, becomes ready
        cycle("R4", 1,0,0, 0,0,0,0, 1,5, 0,0,0, 0,0,0);
        // R6: issue claims entry 0
        cycle("R6", 0,0,0, 0,0,0,0, 0,0, 1,0,0, 0,0,0);
        // R2: read-after-write on r5 into slot 1
        cycle("R2", 1,0,1, 1,5,0,0, 0,0, 0,0,0, 0,0,0);
        // R5: issue of a blocked slot is ignored
        cycle("R5", 0,0,0, 0,0,0,0, 0,0, 1,0,1, 0,0,0);
        // R3: decode into occupied slot 1 is ignored
        cycle("R3", 1,0,1, 0,0,0,0, 0,0, 0,0,0, 0,0,0);
        // R2: write-after-write on r5 into slot 0
        cycle("R2", 1,0,0, 0,0,0,0, 1,5, 0,0,0, 0,0,0);
        // R8: writeback of warp 0 entry 0 clears both slots
        cycle("R8", 0,0,0, 0,0,0,0, 0,0, 0,0,0, 1,0,0);
        idle("R8");
        // R7: fill every entry of warp 1
        for (int k = 0; k < E; k++) begin
            cycle("R7", 1,1,0, 0,0,0,0, 1,8+k, 0,0,0, 0,0,0);
            cycle("R6", 0,0,0, 0,0,0,0, 0,0, 1,1,0, 0,0,0);
        end
        cycle("R7", 1,1,0, 0,0,0,0, 1,12, 0,0,0, 0,0,0);
        cycle("R7", 1,1,1, 1,1,0,0, 0,0, 1,1,0, 0,0,0);
        cycle("R7", 0,0,0, 0,0,0,0, 0,0, 1,1,1, 0,0,0);
        // R11: out-of-order release, entry 2 first, then reuse it
        cycle("R11", 0,0,0, 0,0,0,0, 0,0, 0,0,0, 1,1,2);
        cycle("R11", 0,0,0, 0,0,0,0, 0,0, 1,1,0, 0,0,0);
        cycle("R11", 0,0,0, 0,0,0,0, 0,0, 0,0,0, 1,1,0);
        cycle("R11", 0,0,0, 0,0,0,0, 0,0, 0,0,0, 1,1,1);
        idle("R11");
        // R9: writeback beats a same-cycle dependent decode
        cycle("R9", 1,2,0, 0,0,0,0, 1,3, 0,0,0, 0,0,0);
        cycle("R9", 0,0,0, 0,0,0,0, 0,0, 1,2,0, 0,0,0);
        cycle("R9", 1,2,0, 1,3,0,0, 0,0, 0,0,0, 1,2,0);
        idle("R9");
        // R10: allocation visible to same-cycle decode
        cycle("R10", 1,3,0, 0,0,0,0, 1,7, 0,0,0, 0,0,0);
        cycle("R10", 1,3,1, 1,7,0,0, 0,0, 1,3,0, 0,0,0);
        idle("R10");
        cycle("R8", 0,0,0, 0,0,0,0, 0,0, 0,0,0, 1,3,0);
        idle("R8");
        // Pseudo-random run covering R2..R11 together
        x = 32'h1234_5678;
        for (int n = 0; n < 4000; n++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            cycle("R2_R11_mix",
                  int'(x[0]), int'(x[2:1]), int'(x[3]),
                  int'(x[4]), int'(x[7:5]), int'(x[8]), int'(x[11:9]),
                  int'(x[12]), int'(x[15:13]),
                  int'(x[16] | x[17]), int'(x[19:18]), int'(x[20]),
                  int'(x[21] & x[22]), int'(x[26:25]), int'(x[24:23]) % E);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule